// File: doc/BRIEF.md
# 8-bit ALU with Decimal Adjust and 16-bit Address Adds

A purely combinational arithmetic and logic unit for a small 8-bit processor datapath. In one evaluation it takes an operation select, two 16-bit operands and the current packed flag byte. It returns a 16-bit result, a new flag byte and a four-bit write mask. Byte operations read only the low byte of each operand. The two 16-bit operations read the full words: one adds a signed 8-bit offset to a stack pointer, the other adds two register pairs.

The flags are zero, subtract, half-carry and carry. Each one is computed exactly for each operation. A flag that an operation does not touch passes through from the input, and its write-mask bit reads 0. The decimal adjust uses the incoming subtract flag to choose a correction path. After an addition it adds the correction and may set carry. After a subtraction it removes the correction and keeps carry.

Top module: `alu8_bcd`

## Requirements
- R1: The flag byte carries zero in bit 7, subtract in bit 6, half-carry in bit 5 and carry in bit 4. Bits 3..0 of `flags_out` are always 0. `flags_we` bit 3 is zero, bit 2 subtract, bit 1 half-carry, bit 0 carry. A flag whose mask bit is 0 is output equal to its `flags_in` value.
- R2: `op_sel` encoding: 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 compare, 5 AND, 6 OR, 7 XOR, 8 increment, 9 decrement, 10 decimal adjust, 11 complement, 12 set carry, 13 toggle carry, 14 stack pointer plus signed offset, 15 register-pair add.
- R3: Add and add-with-carry write all four flags. Subtract is cleared. Half-carry is the carry out of bit 3 and carry the carry out of bit 7. Add-with-carry includes the incoming carry in both. Zero is set when the 8-bit result is 0.
- R4: Subtract, subtract-with-borrow and compare set the subtract flag. Half-carry is the borrow from the low nibble and carry is the full 8-bit borrow, with the incoming carry as borrow-in for subtract-with-borrow. Zero reflects the difference. Compare returns operand A unchanged.
- R5: AND sets half-carry and clears subtract and carry. OR and XOR clear all three. Zero reflects the result.
- R6: Increment and decrement act on operand A and do not write carry. Increment sets half-carry when the low nibble was 0xF. Decrement sets half-carry when the low nibble was 0x0, and also sets subtract.
- R7: Decimal adjust with subtract clear adds 0x06 if the low nibble exceeds 9 or half-carry is set. Then, if that value exceeds 0x9F or carry was set, it adds 0x60 and sets carry; otherwise it clears carry.
- R8: Decimal adjust with subtract set subtracts 0x06 if half-carry is set and 0x60 if carry is set, and carry keeps its value. In both decimal-adjust paths half-carry is cleared, zero reflects the result and subtract is not written.
- R9: Complement inverts operand A and sets half-carry and subtract. Set-carry forces carry to 1 and toggle-carry inverts it. Both clear half-carry and subtract and return A. None of the three writes zero.
- R10: The stack-pointer add returns A plus the sign-extended low byte of B, modulo 2^16. It clears zero and subtract. Half-carry comes from the unsigned sum of the low nibbles and carry from the unsigned sum of the low bytes.
- R11: The register-pair add returns A plus B modulo 2^16. It clears subtract and does not write zero. Half-carry is the carry out of bit 11 and carry the carry out of bit 15.
- R12: For the byte operations (codes 0..13), bits 15..8 of the result are 0 and the upper bytes of both operands have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation select (encoding in R2) |
| a_in | input | 16 | Operand A; low byte is the accumulator for byte operations |
| b_in | input | 16 | Operand B; low byte for byte operations and the offset |
| flags_in | input | 8 | Current packed flag byte |
| res_out | output | 16 | Result |
| flags_out | output | 8 | New packed flag byte |
| flags_we | output | 4 | Per-flag write mask: zero, subtract, half-carry, carry |

## Verification
The byte arithmetic operations are swept over every accumulator value against a stride of B values, with both carry-in states. This separates nibble-carry errors from byte-carry errors and shows whether the carry-in is used. Decimal adjust, increment, decrement and the carry operations are swept over all accumulator values under all sixteen combinations of the incoming flags. That covers both decimal-adjust paths and the pass-through of unwritten flags. The 16-bit adds use stepped word operands plus explicit corner values at 0x0FFF, 0xFFFF and negative offsets. These tell the bit-11/15 flags apart from the nibble/byte flags of the offset add. Scrambled upper operand bytes on every byte operation show that the upper byte is ignored.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

   typedef enum logic [3:0] {
      OP_ADD   = 4'd0,
      OP_ADC   = 4'd1,
      OP_SUB   = 4'd2,
      OP_SBC   = 4'd3,
      OP_CMP   = 4'd4,
      OP_AND   = 4'd5,
      OP_OR    = 4'd6,
      OP_XOR   = 4'd7,
      OP_INC   = 4'd8,
      OP_DEC   = 4'd9,
      OP_DADJ  = 4'd10,
      OP_CPL   = 4'd11,
      OP_SCF   = 4'd12,
      OP_CCF   = 4'd13,
      OP_SPOFF = 4'd14,
      OP_PAIR  = 4'd15
   } alu_op_e;

   // positions inside the packed flag byte (upper nibble)
   localparam int FLAG_Z = 7;
   localparam int FLAG_N = 6;
   localparam int FLAG_H = 5;
   localparam int FLAG_C = 4;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
   parameter int W = 8
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  logic         cin,
   input  logic         sub,
   output logic [W-1:0] sum,
   output logic         half,
   output logic         carry
);
   localparam int NIB = W / 2;

   logic [W-1:0] ym;
   logic         ci;
   logic [NIB:0] lo;
   logic [W:0]   full;

   // x - y - b == x + ~y + ~b ; borrow is the inverted carry out
   always_comb begin
      ym    = sub ? ~y : y;
      ci    = sub ? ~cin : cin;
      lo    = {1'b0, x[NIB-1:0]} + {1'b0, ym[NIB-1:0]} + {{NIB{1'b0}}, ci};
      full  = {1'b0, x} + {1'b0, ym} + {{W{1'b0}}, ci};
      sum   = full[W-1:0];
      half  = lo[NIB] ^ sub;
      carry = full[W] ^ sub;
   end

   always_comb begin
      if (sub) begin
         assert_borrow_R4 : assert (carry == ({1'b0, x} < ({1'b0, y} + {{W{1'b0}}, cin})))
            else $error("borrow mismatch");
      end
   end

endmodule

// File: rtl/alu8_decadj.sv
module alu8_decadj #(
   parameter int W      = 8,
   parameter bit ENABLE = 1'b1
) (
   input  logic [W-1:0] a,
   input  logic         n_in,
   input  logic         h_in,
   input  logic         c_in,
   output logic [W-1:0] r,
   output logic         c_out
);
   localparam int NIB = W / 2;
   localparam logic [W:0]   STEP_LO  = (W+1)'(6);
   localparam logic [W:0]   LIMIT    = (W+1)'(159);
   localparam logic [W-1:0] FIX_LO   = W'(6);
   localparam logic [W-1:0] FIX_HI   = W'(96);
   localparam logic [NIB-1:0] NINE   = NIB'(9);

   generate
      if (ENABLE) begin : g_adjust
         logic [W:0]   step1;
         logic         big;
         logic [W-1:0] r_add;
         logic [W-1:0] r_sub;

         always_comb begin
            step1 = {1'b0, a} + (((a[NIB-1:0] > NINE) || h_in) ? STEP_LO : '0);
            big   = (step1 > LIMIT) || c_in;
            r_add = step1[W-1:0] + (big ? FIX_HI : '0);
            r_sub = a - (h_in ? FIX_LO : '0) - (c_in ? FIX_HI : '0);
            r     = n_in ? r_sub : r_add;
            c_out = n_in ? c_in : big;
         end

         always_comb begin
            if (n_in) begin
               assert_sub_keeps_carry_R8 : assert (c_out == c_in)
                  else $error("decimal adjust changed carry on subtract path");
            end else if (c_in) begin
               assert_add_sets_carry_R7 : assert (c_out)
                  else $error("decimal adjust lost carry on add path");
            end
         end
      end else begin : g_bypass
         always_comb begin
            r     = a;
            c_out = c_in;
         end
      end
   endgenerate

endmodule

// File: rtl/alu8_wide.sv
module alu8_wide #(
   parameter int W = 8
) (
   input  logic [2*W-1:0] a,
   input  logic [2*W-1:0] b,
   input  logic           sp_mode,
   output logic [2*W-1:0] r,
   output logic           half,
   output logic           carry
);
   localparam int WW  = 2 * W;
   localparam int NIB = W / 2;
   localparam int HB  = WW - NIB;

   logic [WW-1:0] bop;
   logic [WW:0]   full;
   logic [NIB:0]  lo;
   logic [W:0]    byte_sum;
   logic [HB:0]   upper;

   always_comb begin
      bop      = sp_mode ? {{W{b[W-1]}}, b[W-1:0]} : b;
      full     = {1'b0, a} + {1'b0, bop};
      lo       = {1'b0, a[NIB-1:0]} + {1'b0, bop[NIB-1:0]};
      byte_sum = {1'b0, a[W-1:0]} + {1'b0, bop[W-1:0]};
      upper    = {1'b0, a[HB-1:0]} + {1'b0, bop[HB-1:0]};
      r        = full[WW-1:0];
      half     = sp_mode ? lo[NIB] : upper[HB];
      carry    = sp_mode ? byte_sum[W] : full[WW];
   end

   always_comb begin
      if (!sp_mode) begin
         assert_pair_wrap_R11 : assert (carry == (r < a))
            else $error("pair add carry disagrees with wrap");
      end
   end

endmodule

// File: rtl/alu8_bcd.sv
module alu8_bcd
   import alu8_pkg::*;
#(
   parameter int W      = 8,
   parameter bit DAA_EN = 1'b1
) (
   input  logic [3:0]     op_sel,
   input  logic [2*W-1:0] a_in,
   input  logic [2*W-1:0] b_in,
   input  logic [W-1:0]   flags_in,
   output logic [2*W-1:0] res_out,
   output logic [W-1:0]   flags_out,
   output logic [3:0]     flags_we
);
   localparam int WW = 2 * W;

   generate
      if (W != 8) begin : g_bad_width
         $error("alu8_bcd: flag layout and decimal adjust need W == 8");
      end
   endgenerate

   alu_op_e     op;
   logic [W-1:0] a8, b8, y_sel, lg;
   logic        fz, fn, fh, fc;
   logic        cin_sel, sub_sel;
   logic [W-1:0] as_sum;
   logic        as_half, as_carry;
   logic [W-1:0] da_res;
   logic        da_c;
   logic [WW-1:0] wd_res;
   logic        wd_half, wd_carry;
   logic        z, n, h, c;
   logic [3:0]  we;

   always_comb begin
      op      = alu_op_e'(op_sel);
      a8      = a_in[W-1:0];
      b8      = b_in[W-1:0];
      fz      = flags_in[FLAG_Z];
      fn      = flags_in[FLAG_N];
      fh      = flags_in[FLAG_H];
      fc      = flags_in[FLAG_C];
      y_sel   = (op == OP_INC || op == OP_DEC) ? W'(1) : b8;
      cin_sel = (op == OP_ADC || op == OP_SBC) ? fc : 1'b0;
      sub_sel = (op == OP_SUB || op == OP_SBC || op == OP_CMP || op == OP_DEC);
   end

   alu8_addsub #(.W(W)) u_addsub (
      .x(a8), .y(y_sel), .cin(cin_sel), .sub(sub_sel),
      .sum(as_sum), .half(as_half), .carry(as_carry)
   );

   alu8_decadj #(.W(W), .ENABLE(DAA_EN)) u_decadj (
      .a(a8), .n_in(fn), .h_in(fh), .c_in(fc),
      .r(da_res), .c_out(da_c)
   );

   alu8_wide #(.W(W)) u_wide (
      .a(a_in), .b(b_in), .sp_mode(op == OP_SPOFF),
      .r(wd_res), .half(wd_half), .carry(wd_carry)
   );

   always_comb begin
      res_out = {{W{1'b0}}, a8};
      lg      = '0;
      z = fz; n = fn; h = fh; c = fc;
      we = 4'b0000;
      case (op)
         OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
            res_out = {{W{1'b0}}, as_sum};
            z = (as_sum == '0); n = sub_sel; h = as_half; c = as_carry;
            we = 4'b1111;
         end
         OP_CMP: begin
            z = (as_sum == '0); n = 1'b1; h = as_half; c = as_carry;
            we = 4'b1111;
         end
         OP_AND, OP_OR, OP_XOR: begin
            lg = (op == OP_AND) ? (a8 & b8) : (op == OP_OR) ? (a8 | b8) : (a8 ^ b8);
            res_out = {{W{1'b0}}, lg};
            z = (lg == '0); n = 1'b0; h = (op == OP_AND); c = 1'b0;
            we = 4'b1111;
         end
         OP_INC, OP_DEC: begin
            res_out = {{W{1'b0}}, as_sum};
            z = (as_sum == '0); n = sub_sel; h = as_half;
            we = 4'b1110;
         end
         OP_DADJ: begin
            res_out = {{W{1'b0}}, da_res};
            z = (da_res == '0); h = 1'b0; c = da_c;
            we = 4'b1011;
         end
         OP_CPL: begin
            res_out = {{W{1'b0}}, ~a8};
            n = 1'b1; h = 1'b1;
            we = 4'b0110;
         end
         OP_SCF, OP_CCF: begin
            n = 1'b0; h = 1'b0; c = (op == OP_SCF) ? 1'b1 : ~fc;
            we = 4'b0111;
         end
         OP_SPOFF: begin
            res_out = wd_res;
            z = 1'b0; n = 1'b0; h = wd_half; c = wd_carry;
            we = 4'b1111;
         end
         OP_PAIR: begin
            res_out = wd_res;
            n = 1'b0; h = wd_half; c = wd_carry;
            we = 4'b0111;
         end
         default: ;
      endcase
      flags_we  = we;
      flags_out = {we[3] ? z : fz, we[2] ? n : fn, we[1] ? h : fh, we[0] ? c : fc, 4'b0000};
   end

   always_comb begin
      if (op == OP_CMP) begin
         assert_cmp_keeps_a_R4 : assert (res_out[W-1:0] == a8 && flags_out[FLAG_Z] == (a8 == b8))
            else $error("compare altered A or zero flag wrong");
      end
      if (op == OP_AND || op == OP_OR || op == OP_XOR) begin
         assert_logic_no_carry_R5 : assert (!flags_out[FLAG_C] && !flags_out[FLAG_N])
            else $error("logic op left carry or subtract set");
      end
      if (op == OP_INC || op == OP_DEC) begin
         assert_incdec_keep_carry_R6 : assert (flags_out[FLAG_C] == flags_in[FLAG_C])
            else $error("inc/dec touched carry");
      end
      if (op == OP_SPOFF) begin
         assert_sp_zero_clear_R10 : assert (flags_out[FLAG_Z:FLAG_N] == 2'b00)
            else $error("offset add left zero or subtract set");
      end
      if (op_sel < 4'd14) begin
         assert_upper_zero_R12 : assert (res_out[WW-1:W] == '0)
            else $error("byte op produced upper bits");
      end
   end

endmodule

// File: tb/alu8_bcd_tb.sv
module alu8_bcd_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  op_sel = '0;
   logic [15:0] a_in = '0, b_in = '0;
   logic [7:0]  flags_in = '0;
   logic [15:0] res_out;
   logic [7:0]  flags_out;
   logic [3:0]  flags_we;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   alu8_bcd dut_i (
      .op_sel(op_sel), .a_in(a_in), .b_in(b_in), .flags_in(flags_in),
      .res_out(res_out), .flags_out(flags_out), .flags_we(flags_we)
   );

   function automatic string req_of(input int op);
      case (op)
         0, 1:         return "R3";
         2, 3, 4:      return "R4";
         5, 6, 7:      return "R5";
         8, 9:         return "R6";
         10:           return "R7/R8";
         11, 12, 13:   return "R9";
         14:           return "R10";
         default:      return "R11";
      endcase
   endfunction

   task automatic model(input int op, input int A, input int B, input int F,
                        output logic [15:0] er, output logic [7:0] ef, output logic [3:0] em);
      int a, b, r, ci, off;
      int fz, fn, fh, fc, z, n, h, c;
      a = A & 255; b = B & 255;
      fz = (F >> 7) & 1; fn = (F >> 6) & 1; fh = (F >> 5) & 1; fc = (F >> 4) & 1;
      z = fz; n = fn; h = fh; c = fc; r = a; em = 4'b0000;
      case (op)
         0, 1: begin
            ci = (op == 1) ? fc : 0;
            r = a + b + ci;
            h = (((a & 15) + (b & 15) + ci) > 15) ? 1 : 0;
            c = (r > 255) ? 1 : 0; n = 0; z = ((r & 255) == 0) ? 1 : 0;
            em = 4'b1111;
         end
         2, 3, 4: begin
            ci = (op == 3) ? fc : 0;
            r = a - b - ci;
            h = (((a & 15) - (b & 15) - ci) < 0) ? 1 : 0;
            c = (r < 0) ? 1 : 0; n = 1; z = ((r & 255) == 0) ? 1 : 0;
            if (op == 4) r = a;
            em = 4'b1111;
         end
         5, 6, 7: begin
            r = (op == 5) ? (a & b) : (op == 6) ? (a | b) : (a ^ b);
            z = (r == 0) ? 1 : 0; n = 0; c = 0; h = (op == 5) ? 1 : 0;
            em = 4'b1111;
         end
         8: begin
            h = ((a & 15) == 15) ? 1 : 0; r = a + 1; n = 0;
            z = ((r & 255) == 0) ? 1 : 0; em = 4'b1110;
         end
         9: begin
            h = ((a & 15) == 0) ? 1 : 0; r = a - 1; n = 1;
            z = ((r & 255) == 0) ? 1 : 0; em = 4'b1110;
         end
         10: begin
            if (fn == 1) begin
               if (fh == 1) r = r - 6;
               if (fc == 1) r = r - 96;
               c = fc;
            end else begin
               if ((a & 15) > 9 || fh == 1) r = r + 6;
               if (r > 159 || fc == 1) begin r = r + 96; c = 1; end
               else c = 0;
            end
            r = r & 255; h = 0; z = (r == 0) ? 1 : 0; em = 4'b1011;
         end
         11: begin r = (~a) & 255; h = 1; n = 1; em = 4'b0110; end
         12: begin c = 1; h = 0; n = 0; em = 4'b0111; end
         13: begin c = 1 - fc; h = 0; n = 0; em = 4'b0111; end
         14: begin
            off = (b > 127) ? b - 256 : b;
            r = ((A & 65535) + off) & 65535;
            h = (((A & 15) + (b & 15)) > 15) ? 1 : 0;
            c = (((A & 255) + b) > 255) ? 1 : 0;
            z = 0; n = 0; em = 4'b1111;
         end
         default: begin
            r = (A & 65535) + (B & 65535);
            h = (((A & 4095) + (B & 4095)) > 4095) ? 1 : 0;
            c = (r > 65535) ? 1 : 0; r = r & 65535; n = 0; em = 4'b0111;
         end
      endcase
      if (op < 14) er = 16'(r & 255);
      else         er = 16'(r);
      ef = {1'(z), 1'(n), 1'(h), 1'(c), 4'b0000};
   endtask

   task automatic apply(input int op, input int A, input int B, input int F);
      logic [15:0] er; logic [7:0] ef; logic [3:0] em;
      op_sel = 4'(op); a_in = 16'(A); b_in = 16'(B); flags_in = 8'(F);
      #1;
      model(op, A, B, F, er, ef, em);
      n_cmp++;
      if (res_out !== er || flags_out !== ef || flags_we !== em) begin
         n_bad++;
         $display("FAIL %s op=%0d a=%h b=%h f=%h : got res=%h flags=%h we=%b, expected res=%h flags=%h we=%b",
                  req_of(op), op, A[15:0], B[15:0], F[7:0], res_out, flags_out, flags_we, er, ef, em);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(150000 * 8);
      n_bad++;
      $display("FAIL watchdog: got run still active, expected completion");
      finish_run();
   end

   initial begin
      repeat (4) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // idle inputs: add of zeros gives zero result and zero flag (R3)
      apply(0, 0, 0, 0);

      // R3 / R4 arithmetic, upper bytes scrambled for R12
      for (int op = 0; op <= 4; op++)
         for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b += 5)
               for (int ci = 0; ci < 2; ci++)
                  apply(op, ((a * 7) & 255) << 8 | a, ((b + 91) & 255) << 8 | b,
                        (ci << 4) | (((a + b) & 3) << 6) | ((b & 1) << 5));

      // R5 logic ops with varied incoming flags
      for (int op = 5; op <= 7; op++)
         for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b += 3)
               apply(op, 16'hA500 | a, 16'h5A00 | b, ((a ^ b) & 15) << 4);

      // R6, R7, R8, R9: every accumulator under every flag combination (R1 pass-through)
      for (int op = 8; op <= 13; op++)
         for (int a = 0; a < 256; a++)
            for (int fl = 0; fl < 16; fl++)
               apply(op, 16'hFF00 | a, 16'h1234, fl << 4);

      // R10 stack-pointer plus signed offset
      for (int i = 0; i < 256; i++)
         for (int b = 0; b < 256; b++)
            apply(14, (i * 257 + 3) & 65535, 16'h7700 | b, (i & 15) << 4);

      // R11 register-pair add
      for (int i = 0; i < 256; i++)
         for (int j = 0; j < 250; j++)
            apply(15, (i * 257) & 65535, (j * 263) & 65535, (j & 15) << 4);

      // explicit corners: R11 bit-11 and bit-15 carries, R10 negative offsets
      apply(15, 16'h0FFF, 16'h0001, 8'h80);
      apply(15, 16'hFFFF, 16'h0001, 8'h00);
      apply(15, 16'h8000, 16'h8000, 8'hF0);
      apply(14, 16'h0000, 16'h00FF, 8'hF0);
      apply(14, 16'h00FF, 16'h0001, 8'h00);
      apply(14, 16'h1000, 16'h0080, 8'h00);
      // R7 / R8 decimal-adjust corners
      apply(10, 16'h009A, 0, 8'h00);
      apply(10, 16'h0000, 0, 8'h70);
      apply(10, 16'h0066, 0, 8'h70);
      // R12 upper operand bytes ignored, R2 code 12 set-carry
      apply(0, 16'hFF01, 16'hFFFF, 8'h00);
      apply(12, 16'hABCD, 16'hFFFF, 8'h80);

      finish_run();
   end

endmodule